// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block runs single elementary operations on an 8-bit NAND flash bus for a host that addresses it through a small 16-bit register file. The host loads an opcode, an address byte, a sector number and the transfer options. It then writes a trigger word in which exactly one bit names the operation: a command latch, an address latch, a program transfer from the internal buffer to the flash, a page read from the flash into the buffer, an identifier read or a status read. The sequencer drives the latch enables, the write and read strobes and the data byte. It moves bytes between the flash and a local byte buffer. When the flash reports ready, it sets a sticky completion flag.

The buffer holds four 512-byte main sectors, followed by four 16-byte spare areas, so the spare areas begin at byte 2048. The host reaches the buffer through its own byte port. The sector number chooses which main sector and which spare area a transfer uses. A spare-only option limits a page transfer to that spare area.

The controller is one state machine with four states. ST_IDLE waits for a valid trigger. ST_LOW holds the active strobe low for the setup count. ST_HIGH holds it high for the hold count. ST_WAITRB waits for the ready/busy line. The transitions are as follows. From ST_IDLE to ST_LOW on an accepted trigger. From ST_LOW to ST_HIGH when the setup count expires. From ST_HIGH back to ST_LOW when the hold count expires and bytes remain. From ST_HIGH to ST_WAITRB after the last byte. From ST_WAITRB to ST_IDLE, setting the completion flag, on the first clock that samples ready/busy high.

Top module: `nandc_op_engine`

## Requirements
- R1: After reset, every register reads zero except the timing register, which reads 0x0033. The strobes are high, CLE, ALE and the data output enable are low, and the busy bit (bit 14 of register 5) and the completion bit (bit 15 of register 5) are 0.
- R2: Trigger 0x0001 written to register 5 performs one command cycle. CLE stays high for the whole cycle, and the data output enable is high with the byte from register 0 on the bus. Write strobe low lasts exactly the setup count, and write strobe high after it lasts the hold count.
- R3: Trigger 0x0002 performs one address cycle with the same strobe timing, ALE high and the byte from register 1 on the bus.
- R4: Trigger 0x0008 reads 528 bytes with the read strobe: low for the setup count, then high for the hold count, with each byte taken as the strobe rises. Byte k < 512 goes to buffer address 512*n + k, and byte k >= 512 goes to 2048 + 16*n + (k - 512), where n is register 2. No other buffer byte changes.
- R5: With bit 2 of register 3 set, a page read or program covers only 16 bytes, at buffer addresses 2048 + 16*n + k.
- R6: Trigger 0x0004 drives 528 bytes (16 with bit 2 of register 3 set) on the bus with the write strobe, taken from the buffer in the order R4 gives.
- R7: Trigger 0x0010 reads 4 identifier bytes into buffer addresses 512*n to 512*n + 3.
- R8: Trigger 0x0020 reads one status byte into buffer address 512*n. Byte 512*n + 1 is unchanged.
- R9: The completion bit is set when an operation ends. A write of register 5 with bit 15 set leaves it set. A write with bit 15 clear, made while idle, clears it.
- R10: After its last strobe, every operation waits while the ready/busy input is low. The completion bit is set on the first clock edge that samples that input high, and the core stays busy until then.
- R11: While an operation runs, the busy bit reads 1, and a write of register 5 has no effect on the bus sequence or on the completion bit.
- R12: A trigger word whose bits 5..0 hold zero or more than one set bit starts no operation.
- R13: Register 4 holds the setup count in bits 3..0 and the hold count in bits 7..4, and reads back as written. A count of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 opcode, 1 address byte, 2 sector, 3 options, 4 timing, 5 trigger) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| buf_we | input | 1 | Host buffer byte write |
| buf_addr | input | 12 | Host buffer byte address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_rdata | output | 8 | Host buffer read data at buf_addr |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_io_out | output | 8 | Data byte driven to the flash |
| nf_io_oe | output | 1 | Output enable for nf_io_out |
| nf_io_in | input | 8 | Data byte from the flash |
| nf_rb | input | 1 | Ready/busy from the flash, high when ready |

## Verification
The assertions assume that the host writes the trigger register while idle only to start work or to clear the flag. They also assume that ready/busy changes only between clock edges, so each edge in ST_WAITRB sees a settled value. The host is also assumed to leave the buffer alone while a transfer runs, because the sequencer's own writes take precedence there. The stimulus drives every input just after a rising edge. It touches the buffer port only while the core is idle. It holds ready/busy low for a chosen number of cycles, set at the cycle the trigger is issued, so the sequence never depends on how one edge is ordered against another.

// File: rtl/nandc_pkg.sv
package nandc_pkg;

    typedef enum logic [2:0] {
        OP_CMD  = 3'd0,
        OP_ADDR = 3'd1,
        OP_DIN  = 3'd2,
        OP_DOUT = 3'd3,
        OP_ID   = 3'd4,
        OP_STAT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_WAITRB = 2'd3
    } st_e;

    localparam logic [2:0] REG_OPC   = 3'd0;
    localparam logic [2:0] REG_ADB   = 3'd1;
    localparam logic [2:0] REG_SECT  = 3'd2;
    localparam logic [2:0] REG_OPTS  = 3'd3;
    localparam logic [2:0] REG_TIME  = 3'd4;
    localparam logic [2:0] REG_TRIG  = 3'd5;

    localparam int TRIG_BITS  = 6;
    localparam int DONE_BIT   = 15;
    localparam int BUSY_BIT   = 14;
    localparam int SPARE_BIT  = 2;

endpackage

// File: rtl/nandc_regs.sv
module nandc_regs
    import nandc_pkg::*;
#(
    parameter int AREAS    = 4,
    parameter int TW       = 4,
    parameter int TIME_RST = 3,
    localparam int BW      = $clog2(AREAS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          eng_busy,
    input  logic          eng_end,
    output logic [7:0]    cmd_byte,
    output logic [7:0]    addr_byte,
    output logic [BW-1:0] buf_num,
    output logic          spare_en,
    output logic [TW-1:0] t_setup,
    output logic [TW-1:0] t_hold,
    output logic          start,
    output op_e           start_op,
    output logic          done_flag
);

    logic [7:0]    opc_q, adb_q;
    logic [BW-1:0] sect_q;
    logic          spare_q;
    logic [TW-1:0] setup_q, hold_q;
    logic          done_q;
    logic          trig_wr, one_hot;

    assign trig_wr = reg_wr && (reg_addr == REG_TRIG);
    assign one_hot = ($countones(reg_wdata[TRIG_BITS-1:0]) == 1);
    assign start   = trig_wr && !eng_busy && one_hot;

    always_comb begin
        if (reg_wdata[0])      start_op = OP_CMD;
        else if (reg_wdata[1]) start_op = OP_ADDR;
        else if (reg_wdata[2]) start_op = OP_DIN;
        else if (reg_wdata[3]) start_op = OP_DOUT;
        else if (reg_wdata[4]) start_op = OP_ID;
        else                   start_op = OP_STAT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q   <= '0;
            adb_q   <= '0;
            sect_q  <= '0;
            spare_q <= 1'b0;
            setup_q <= TW'(TIME_RST);
            hold_q  <= TW'(TIME_RST);
            done_q  <= 1'b0;
        end else begin
            if (reg_wr) begin
                unique case (reg_addr)
                    REG_OPC:  opc_q   <= reg_wdata[7:0];
                    REG_ADB:  adb_q   <= reg_wdata[7:0];
                    REG_SECT: sect_q  <= reg_wdata[BW-1:0];
                    REG_OPTS: spare_q <= reg_wdata[SPARE_BIT];
                    REG_TIME: begin
                        setup_q <= reg_wdata[TW-1:0];
                        hold_q  <= reg_wdata[2*TW-1:TW];
                    end
                    default: ;
                endcase
            end
            if (eng_end)
                done_q <= 1'b1;
            else if (trig_wr && !eng_busy && !reg_wdata[DONE_BIT])
                done_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (reg_addr)
            REG_OPC:  reg_rdata = {8'h00, opc_q};
            REG_ADB:  reg_rdata = {8'h00, adb_q};
            REG_SECT: reg_rdata = 16'(sect_q);
            REG_OPTS: reg_rdata = 16'({spare_q, 2'b00});
            REG_TIME: reg_rdata = 16'({hold_q, setup_q});
            REG_TRIG: reg_rdata = {done_q, eng_busy, 14'h0000};
            default:  reg_rdata = 16'h0000;
        endcase
    end

    assign cmd_byte  = opc_q;
    assign addr_byte = adb_q;
    assign buf_num   = sect_q;
    assign spare_en  = spare_q;
    assign t_setup   = (setup_q == '0) ? TW'(1) : setup_q;
    assign t_hold    = (hold_q  == '0) ? TW'(1) : hold_q;
    assign done_flag = done_q;

endmodule

// File: rtl/nandc_buffer.sv
module nandc_buffer #(
    parameter int DEPTH = 2112,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    input  logic          e_we,
    input  logic [AW-1:0] e_addr,
    input  logic [7:0]    e_wdata,
    output logic [7:0]    e_rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (e_we)
            mem[e_addr] <= e_wdata;
        else if (h_we)
            mem[h_addr] <= h_wdata;
    end

    assign h_rdata = mem[h_addr];
    assign e_rdata = mem[e_addr];

endmodule

// File: rtl/nandc_seq.sv
module nandc_seq
    import nandc_pkg::*;
#(
    parameter int AREAS    = 4,
    parameter int SECT     = 512,
    parameter int SPARE    = 16,
    parameter int ID_BYTES = 4,
    parameter int TW       = 4,
    localparam int BW      = $clog2(AREAS),
    localparam int DEPTH   = AREAS * (SECT + SPARE),
    localparam int AW      = $clog2(DEPTH),
    localparam int XW      = $clog2(SECT + SPARE + 1),
    localparam int SP_BASE = AREAS * SECT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  op_e           start_op,
    input  logic [7:0]    cmd_byte,
    input  logic [7:0]    addr_byte,
    input  logic [BW-1:0] buf_num,
    input  logic          spare_en,
    input  logic [TW-1:0] t_setup,
    input  logic [TW-1:0] t_hold,
    input  logic          nf_rb,
    input  logic [7:0]    nf_io_in,
    input  logic [7:0]    e_rdata,
    output logic          busy,
    output logic          op_end,
    output logic          e_we,
    output logic [AW-1:0] e_addr,
    output logic [7:0]    e_wdata,
    output logic          nf_cle,
    output logic          nf_ale,
    output logic          nf_we_n,
    output logic          nf_re_n,
    output logic [7:0]    nf_io_out,
    output logic          nf_io_oe
);

    st_e           st_q, st_d;
    op_e           op_q;
    logic [TW-1:0] cnt_q, setup_q, hold_q;
    logic [XW-1:0] idx_q, last_q;
    logic [BW-1:0] sel_q;
    logic          spare_q;
    logic [7:0]    opc_q, adb_q;
    logic          low_end, high_end, last_byte, is_read, on_bus;

    function automatic logic [XW-1:0] last_of(op_e op, logic sp);
        int n;
        unique case (op)
            OP_ID:          n = ID_BYTES;
            OP_DIN, OP_DOUT: n = sp ? SPARE : SECT + SPARE;
            default:        n = 1;
        endcase
        return XW'(n - 1);
    endfunction

    assign low_end   = (cnt_q == setup_q - TW'(1));
    assign high_end  = (cnt_q == hold_q - TW'(1));
    assign last_byte = (idx_q == last_q);
    assign is_read   = (op_q == OP_DOUT) || (op_q == OP_ID) || (op_q == OP_STAT);
    assign on_bus    = (st_q == ST_LOW) || (st_q == ST_HIGH);

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start)    st_d = ST_LOW;
            ST_LOW:    if (low_end)  st_d = ST_HIGH;
            ST_HIGH:   if (high_end) st_d = last_byte ? ST_WAITRB : ST_LOW;
            ST_WAITRB: if (nf_rb)    st_d = ST_IDLE;
            default:                 st_d = ST_IDLE;
        endcase
    end

    // state and operation registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            op_q    <= OP_CMD;
            cnt_q   <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            sel_q   <= '0;
            spare_q <= 1'b0;
            opc_q   <= '0;
            adb_q   <= '0;
            setup_q <= TW'(1);
            hold_q  <= TW'(1);
        end else begin
            st_q <= st_d;
            if (st_q != st_d)
                cnt_q <= '0;
            else if (on_bus)
                cnt_q <= cnt_q + TW'(1);
            if (st_q == ST_IDLE && start) begin
                op_q    <= start_op;
                idx_q   <= '0;
                last_q  <= last_of(start_op, spare_en);
                sel_q   <= buf_num;
                spare_q <= spare_en;
                opc_q   <= cmd_byte;
                adb_q   <= addr_byte;
                setup_q <= t_setup;
                hold_q  <= t_hold;
            end else if (st_q == ST_HIGH && high_end && !last_byte) begin
                idx_q <= idx_q + XW'(1);
            end
        end
    end

    // buffer address for the current byte
    always_comb begin
        if ((op_q == OP_DIN || op_q == OP_DOUT) && spare_q)
            e_addr = AW'(SP_BASE) + AW'(sel_q) * AW'(SPARE) + AW'(idx_q);
        else if ((op_q == OP_DIN || op_q == OP_DOUT) && (idx_q >= XW'(SECT)))
            e_addr = AW'(SP_BASE) + AW'(sel_q) * AW'(SPARE) + AW'(idx_q) - AW'(SECT);
        else
            e_addr = AW'(sel_q) * AW'(SECT) + AW'(idx_q);
    end

    // outputs
    always_comb begin
        busy      = (st_q != ST_IDLE);
        op_end    = (st_q == ST_WAITRB) && nf_rb;
        nf_cle    = on_bus && (op_q == OP_CMD);
        nf_ale    = on_bus && (op_q == OP_ADDR);
        nf_we_n   = !((st_q == ST_LOW) && !is_read);
        nf_re_n   = !((st_q == ST_LOW) && is_read);
        nf_io_oe  = on_bus && !is_read;
        e_we      = (st_q == ST_LOW) && is_read && low_end;
        e_wdata   = nf_io_in;
        unique case (op_q)
            OP_CMD:  nf_io_out = opc_q;
            OP_ADDR: nf_io_out = adb_q;
            default: nf_io_out = e_rdata;
        endcase
    end

endmodule

// File: rtl/nandc_op_engine.sv
module nandc_op_engine
    import nandc_pkg::*;
#(
    parameter int AREAS    = 4,
    parameter int SECT     = 512,
    parameter int SPARE    = 16,
    parameter int ID_BYTES = 4,
    parameter int TW       = 4,
    parameter int TIME_RST = 3,
    localparam int BW      = $clog2(AREAS),
    localparam int DEPTH   = AREAS * (SECT + SPARE),
    localparam int BAW     = $clog2(DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_wr,
    input  logic [2:0]     reg_addr,
    input  logic [15:0]    reg_wdata,
    output logic [15:0]    reg_rdata,
    input  logic           buf_we,
    input  logic [BAW-1:0] buf_addr,
    input  logic [7:0]     buf_wdata,
    output logic [7:0]     buf_rdata,
    output logic           nf_cle,
    output logic           nf_ale,
    output logic           nf_we_n,
    output logic           nf_re_n,
    output logic [7:0]     nf_io_out,
    output logic           nf_io_oe,
    input  logic [7:0]     nf_io_in,
    input  logic           nf_rb
);

    logic           eng_busy, eng_end, start, spare_en, done_flag;
    op_e            start_op;
    logic [7:0]     cmd_byte, addr_byte;
    logic [BW-1:0]  buf_num;
    logic [TW-1:0]  t_setup, t_hold;
    logic           e_we;
    logic [BAW-1:0] e_addr;
    logic [7:0]     e_wdata, e_rdata;

    nandc_regs #(.AREAS(AREAS), .TW(TW), .TIME_RST(TIME_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .eng_end(eng_end), .cmd_byte(cmd_byte), .addr_byte(addr_byte),
        .buf_num(buf_num), .spare_en(spare_en), .t_setup(t_setup),
        .t_hold(t_hold), .start(start), .start_op(start_op), .done_flag(done_flag)
    );

    nandc_buffer #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .h_we(buf_we), .h_addr(buf_addr), .h_wdata(buf_wdata),
        .h_rdata(buf_rdata), .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata),
        .e_rdata(e_rdata)
    );

    nandc_seq #(.AREAS(AREAS), .SECT(SECT), .SPARE(SPARE), .ID_BYTES(ID_BYTES), .TW(TW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op),
        .cmd_byte(cmd_byte), .addr_byte(addr_byte), .buf_num(buf_num),
        .spare_en(spare_en), .t_setup(t_setup), .t_hold(t_hold), .nf_rb(nf_rb),
        .nf_io_in(nf_io_in), .e_rdata(e_rdata), .busy(eng_busy), .op_end(eng_end),
        .e_we(e_we), .e_addr(e_addr), .e_wdata(e_wdata), .nf_cle(nf_cle),
        .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe)
    );

endmodule

// File: rtl/nandc_sva.sv
module nandc_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic [2:0]  reg_addr,
    input logic [15:0] reg_wdata,
    input logic        eng_busy,
    input logic        done_flag,
    input logic        nf_rb,
    input logic        nf_we_n,
    input logic        nf_re_n,
    input logic        nf_cle,
    input logic        nf_ale,
    input logic        nf_io_oe
);

    logic trig_wr;
    assign trig_wr = reg_wr && (reg_addr == 3'd5);

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_io_oe));

    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nf_we_n && !nf_re_n));

    p_one_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag && !(trig_wr && !reg_wdata[15]) |=> done_flag);

    p_end_via_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> (eng_busy || done_flag));

    p_done_after_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(nf_rb));

    p_trig_ignored_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy && trig_wr && !nf_rb |=> eng_busy);

    p_bad_trigger_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy && trig_wr && ($countones(reg_wdata[5:0]) != 1) |=> !eng_busy);

    p_good_trigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy && trig_wr && ($countones(reg_wdata[5:0]) == 1) |=> eng_busy);

endmodule

bind nandc_op_engine nandc_sva u_sva (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .eng_busy(eng_busy), .done_flag(done_flag),
    .nf_rb(nf_rb), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_cle(nf_cle),
    .nf_ale(nf_ale), .nf_io_oe(nf_io_oe)
);

// File: tb/tb_nandc_op_engine.sv
`timescale 1ns/100ps
module tb_nandc_op_engine;

    typedef struct packed {
        logic we_n, re_n, cle, ale, oe, busy, rb_low, rb_go;
        logic [7:0] io;
    } exp_t;

    localparam exp_t IDLE_E = '{we_n:1'b1, re_n:1'b1, cle:1'b0, ale:1'b0, oe:1'b0,
                                busy:1'b0, rb_low:1'b0, rb_go:1'b0, io:8'h00};

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd5;
    logic [15:0] reg_wdata = '0, reg_rdata;
    logic        buf_we = 1'b0;
    logic [11:0] buf_addr = '0;
    logic [7:0]  buf_wdata = '0, buf_rdata;
    logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_io_oe;
    logic [7:0]  nf_io_out;
    logic [7:0]  nf_io_in = 8'd11;
    logic        nf_rb = 1'b1;

    int cmp = 0, err = 0;
    exp_t expq[$];
    logic [7:0] rd_sent[$];
    logic [7:0] ref_buf [2112];
    int rd_ctr = 0;
    logic prev_re = 1'b1;
    logic model_done = 1'b0;
    string cur_req = "R1";
    int cur_s = 3, cur_h = 3, cur_sel = 0;
    logic cur_spare = 1'b0;
    logic [7:0] cur_cmd = 0, cur_adb = 0;

    nandc_op_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_io_out(nf_io_out), .nf_io_oe(nf_io_oe), .nf_io_in(nf_io_in), .nf_rb(nf_rb)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] expv);
        cmp++;
        if (act !== expv) begin
            err++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    // per-cycle reference comparison and flash model
    always @(negedge clk) begin
        exp_t e;
        if (rst_n) begin
            e = (expq.size() > 0) ? expq.pop_front() : IDLE_E;
            chk(cur_req, {11'd0, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_io_oe},
                {11'd0, e.we_n, e.re_n, e.cle, e.ale, e.oe});
            if (e.oe) chk(cur_req, {8'd0, nf_io_out}, {8'd0, e.io});
            if (reg_addr == 3'd5 && !reg_wr)
                chk(cur_req, {14'd0, reg_rdata[15:14]}, {14'd0, model_done, e.busy});
            if (e.rb_low) nf_rb = 1'b0;
            if (e.rb_go) begin nf_rb = 1'b1; model_done = 1'b1; end
            if (!prev_re && nf_re_n) begin
                rd_sent.push_back(nf_io_in);
                rd_ctr++;
                nf_io_in = 8'(rd_ctr * 37 + 11);
            end
            prev_re = nf_re_n;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        if (a == 3'd5 && !d[15]) model_done = 1'b0;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 3'd5;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [15:0] expv);
        @(posedge clk); #1;
        reg_addr = a; #1;
        chk(req, reg_rdata, expv);
        reg_addr = 3'd5;
    endtask

    function automatic int bidx(input int kind, input int k);
        if (kind == 2 || kind == 3) begin
            if (cur_spare) return 2048 + cur_sel * 16 + k;
            if (k >= 512) return 2048 + cur_sel * 16 + k - 512;
        end
        return cur_sel * 512 + k;
    endfunction

    task automatic verify_buf(input string req);
        for (int i = 0; i < 2112; i++) begin
            buf_addr = 12'(i); #1;
            chk(req, {8'd0, buf_rdata}, {8'd0, ref_buf[i]});
        end
    endtask

    // kind is the trigger bit index; w = cycles ready/busy stays low; poke = cycle of a write while busy
    task automatic run_op(input int kind, input int nb, input int w, input int poke, input string req);
        exp_t e;
        logic rd;
        rd = (kind >= 3);
        @(posedge clk); #1;
        rd_sent.delete();
        cur_req = req;
        reg_wr = 1'b1; reg_addr = 3'd5; reg_wdata = 16'(1 << kind); model_done = 1'b0;
        e = IDLE_E; e.rb_low = (w > 0);
        expq.push_back(e);
        for (int k = 0; k < nb; k++) begin
            e = IDLE_E; e.busy = 1'b1; e.cle = (kind == 0); e.ale = (kind == 1); e.oe = !rd;
            e.io = (kind == 0) ? cur_cmd : (kind == 1) ? cur_adb : (kind == 2) ? ref_buf[bidx(kind, k)] : 8'h00;
            for (int c = 0; c < cur_s; c++) begin
                e.we_n = rd; e.re_n = !rd; expq.push_back(e);
            end
            for (int c = 0; c < cur_h; c++) begin
                e.we_n = 1'b1; e.re_n = 1'b1; expq.push_back(e);
            end
        end
        for (int c = 0; c <= w; c++) begin
            e = IDLE_E; e.busy = 1'b1; e.rb_go = (c == w); expq.push_back(e);
        end
        @(posedge clk); #1;
        reg_wr = 1'b0;
        if (poke > 0) begin
            #1 chk("R11", {15'd0, reg_rdata[14]}, 16'd1);
            repeat (poke) @(posedge clk);
            #1 reg_wr = 1'b1; reg_wdata = 16'h0001;
            @(posedge clk); #1 reg_wr = 1'b0;
        end
        while (expq.size() > 0) @(negedge clk);
        @(posedge clk); #1;
        chk(req, reg_rdata, 16'h8000);
        if (rd) begin
            chk(req, 16'(rd_sent.size()), 16'(nb));
            for (int k = 0; k < nb && k < rd_sent.size(); k++) ref_buf[bidx(kind, k)] = rd_sent[k];
            verify_buf(req);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        err++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp, err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        rd_chk("R1", 3'd0, 16'h0000);
        rd_chk("R1", 3'd2, 16'h0000);
        rd_chk("R1", 3'd3, 16'h0000);
        rd_chk("R1", 3'd4, 16'h0033);
        rd_chk("R1", 3'd5, 16'h0000);
        // preload the buffer
        for (int i = 0; i < 2112; i++) begin
            @(posedge clk); #1;
            buf_we = 1'b1; buf_addr = 12'(i); buf_wdata = 8'(i * 13 + 5); ref_buf[i] = 8'(i * 13 + 5);
        end
        @(posedge clk); #1 buf_we = 1'b0;
        verify_buf("R1");
        // R2: command cycle
        cur_cmd = 8'h90; wr(3'd0, 16'h0090);
        run_op(0, 1, 0, 0, "R2");
        // R3: address cycle
        cur_adb = 8'h5A; wr(3'd1, 16'h005A);
        run_op(1, 1, 2, 0, "R3");
        // R7: identifier read into sector 0
        cur_sel = 0; wr(3'd2, 16'h0000);
        run_op(4, 4, 0, 0, "R7");
        // R8: status read into sector 1
        cur_sel = 1; wr(3'd2, 16'h0001);
        run_op(5, 1, 1, 0, "R8");
        // R4 and R10: full page read into sector 2 with a busy wait
        cur_sel = 2; wr(3'd2, 16'h0002);
        run_op(3, 528, 5, 0, "R4");
        // R5: spare-only read into sector 3
        cur_sel = 3; cur_spare = 1'b1; wr(3'd2, 16'h0003); wr(3'd3, 16'h0004);
        rd_chk("R5", 3'd3, 16'h0004);
        run_op(3, 16, 0, 0, "R5");
        // R6: full page program from sector 1
        cur_sel = 1; cur_spare = 1'b0; wr(3'd2, 16'h0001); wr(3'd3, 16'h0000);
        run_op(2, 528, 3, 0, "R6");
        // R5: spare-only program from sector 0
        cur_sel = 0; cur_spare = 1'b1; wr(3'd2, 16'h0000); wr(3'd3, 16'h0004);
        run_op(2, 16, 0, 0, "R5");
        // R9: sticky completion flag
        cur_req = "R9";
        wr(3'd5, 16'h8000);
        rd_chk("R9", 3'd5, 16'h8000);
        wr(3'd5, 16'h0000);
        rd_chk("R9", 3'd5, 16'h0000);
        // R11 and R10: trigger during a long busy wait is ignored
        cur_cmd = 8'h70; wr(3'd0, 16'h0070);
        run_op(0, 1, 20, 3, "R11");
        // R12: invalid trigger words
        cur_req = "R12";
        wr(3'd5, 16'h0003);
        repeat (4) @(posedge clk);
        rd_chk("R12", 3'd5, 16'h0000);
        wr(3'd5, 16'h0000);
        repeat (4) @(posedge clk);
        rd_chk("R12", 3'd5, 16'h0000);
        // R13: zero setup count acts as one, hold of two
        cur_req = "R13";
        wr(3'd4, 16'h0020);
        rd_chk("R13", 3'd4, 16'h0020);
        cur_s = 1; cur_h = 2; cur_adb = 8'hC3; wr(3'd1, 16'h00C3);
        run_op(1, 1, 0, 0, "R13");
        cur_sel = 2; cur_spare = 1'b0; wr(3'd2, 16'h0002); wr(3'd3, 16'h0000);
        run_op(4, 4, 0, 0, "R13");
        repeat (3) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp, err);
        $finish;
    end

endmodule